// File: doc/BRIEF.md
# Memory-Mapped TLB Address Array Writer

This block keeps the address half of a translation lookaside buffer: a 64-entry main TLB and a 4-entry instruction TLB. Each entry holds a virtual page number, an address-space identifier, a dirty flag and a valid flag. Software reaches the main array through a 32-bit window in the control space. An access can name one main entry by its index. It can also use an associative form. In that form the block looks for the entry that matches a page number and identifier, changes its flags, and passes the change on to the instruction TLB.

The block also owns the replacement counter and its boundary, which sit together in a control word. The counter advances on every main-TLB access, whether it comes from the window or from the translation path through a lookup strobe. When a valid translation is dropped or overwritten, the block sends one flush pulse that carries the page address. When an associative write finds the same translation twice, it raises a multiple-hit exception pulse and latches the faulting window address. The instruction-TLB refill path loads entries through a fill port.

Top module: `tlbmm_addr_array`

## Requirements
- R1: The window data word splits into page number in bits 31:10, dirty in bit 9, valid in bit 8 and identifier in bits 7:0. A write to region 6 with address bit 7 clear loads the whole word into the main entry chosen by address bits 13:8. A read of region 6 returns that entry in the same layout, on `win_rdata` in the cycle after the strobe.
- R2: An indexed write over a valid main entry pulses `flush_req` in the next cycle with `flush_addr` equal to the old page number shifted left by 10. It does so only when no instruction entry is identical to the old main entry in all four fields.
- R3: An indexed write over a valid entry that has an identical copy in the instruction TLB gives no flush pulse.
- R4: An associative write (address bit 7 set) compares only valid main entries, on page number and identifier together. The lowest-index match takes the written valid and dirty flags. Invalid entries and entries whose identifier differs are left unchanged.
- R5: When a second valid main entry matches, the search stops. `exc_pulse` rises in the next cycle with `exc_code` 0x140 and `fault_addr` holding the write address. The second matching entry stays unchanged.
- R6: An associative write also finds the lowest-index instruction entry that matches page number and identifier, whether it is valid or not. If a main entry matched, the instruction entry becomes a copy of the updated main entry. Otherwise only its valid flag takes the written value.
- R7: If any matching entry, main or instruction, goes from valid to invalid during an associative write, `flush_req` pulses with `flush_addr` equal to the written page number shifted left by 10.
- R8: The control word has the counter in bits 15:10 and the boundary in bits 23:18, and `ctl_we` loads both from `ctl_wdata`. Each advance adds one, and the counter returns to 0 when the new value equals the boundary or 63.
- R9: The counter advances once per indexed write, once per `mt_lookup` cycle, and once per valid main entry compared by an associative write before the search ends. The second matching entry is not counted.
- R10: Regions 0, 1, 4 and 5 (address bits 26:24) of the window at 0xF0000000 ignore writes, read as 0 and leave the counter unchanged. Regions 2, 3 and 7, and any address outside the window, pulse `win_err` in the next cycle.
- R11: A synchronous active-low reset clears every valid flag, the counter, the boundary and all pulse outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_we | input | 1 | Window write strobe, one cycle |
| win_re | input | 1 | Window read strobe, one cycle |
| win_addr | input | 32 | Window byte address |
| win_wdata | input | 32 | Window write data |
| win_rdata | output | 32 | Read data, valid the cycle after `win_re` |
| win_err | output | 1 | Pulse for an access to a forbidden region |
| mt_lookup | input | 1 | One main-TLB lookup by the translation path |
| ctl_we | input | 1 | Load counter and boundary |
| ctl_wdata | input | 32 | Control word to load |
| ctl_word | output | 32 | Current control word |
| it_fill_we | input | 1 | Instruction-TLB fill strobe |
| it_fill_idx | input | 2 | Instruction entry to fill |
| it_fill_data | input | 32 | Entry in the window data layout |
| flush_req | output | 1 | One-cycle page flush request |
| flush_addr | output | 32 | Page address to flush |
| exc_pulse | output | 1 | One-cycle multiple-hit exception |
| exc_code | output | 12 | 0x140 while `exc_pulse` is high, else 0 |
| fault_addr | output | 32 | Window address of the last multiple hit |

## Verification
Indexed writes are driven with fresh, overwritten, invalid-before and invalid-after entries. These show whether the flush depends on the old valid flag and whether it carries the old page rather than the new one. Associative writes are driven with no match, one match, two matches around a valid non-match, an identifier mismatch, and an invalid entry that shares a page number. These separate the validity filter, the stop-on-second-match rule and the per-entry counter steps. Instruction-TLB cases pair a main match with a later indexed overwrite, and a lone instruction match with a repeated clear. These tell a full copy apart from a flag-only update. The counter is started just below 63 and just below a nonzero boundary so that each wrap cause can be seen alone.

// File: rtl/tlbmm_pkg.sv
package tlbmm_pkg;

    localparam int VPN_W  = 22;
    localparam int ASID_W = 8;
    localparam int PAGE_SHIFT = 10;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic              d;
        logic              v;
        logic [ASID_W-1:0] asid;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        ACC_OUTSIDE_OR_BAD = 2'd0,
        ACC_IGNORED        = 2'd1,
        ACC_MAIN_TAG       = 2'd2
    } acc_kind_e;

    localparam logic [11:0] EXC_MULTI_HIT = 12'h140;

endpackage

// File: rtl/tlbmm_region_dec.sv
module tlbmm_region_dec
    import tlbmm_pkg::*;
(
    input  logic [4:0] win_top,
    input  logic [2:0] region,
    output acc_kind_e  kind
);
    localparam logic [4:0] WIN_TOP_BITS = 5'b11110;

    always_comb begin
        kind = ACC_OUTSIDE_OR_BAD;
        if (win_top == WIN_TOP_BITS) begin
            unique case (region)
                3'd0, 3'd1, 3'd4, 3'd5: kind = ACC_IGNORED;
                3'd6:                   kind = ACC_MAIN_TAG;
                default:                kind = ACC_OUTSIDE_OR_BAD;
            endcase
        end
    end
endmodule

// File: rtl/tlbmm_mt_search.sv
module tlbmm_mt_search
    import tlbmm_pkg::*;
#(
    parameter  int N     = 64,
    localparam int IDX_W = $clog2(N),
    localparam int CNT_W = $clog2(N + 1)
) (
    input  tlb_ent_t [N-1:0]   ents,
    input  logic [VPN_W-1:0]   key_vpn,
    input  logic [ASID_W-1:0]  key_asid,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic               multi,
    output logic [CNT_W-1:0]   examined
);
    logic [N-1:0] unused_dirty;
    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = ents[g].v && (ents[g].vpn == key_vpn)
                          && (ents[g].asid == key_asid);
        assign unused_dirty[g] = ents[g].d;
    end

    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        multi    = 1'b0;
        examined = '0;
        for (int i = 0; i < N; i++) begin
            if (!multi && ents[i].v) begin
                if (match[i] && hit) begin
                    multi = 1'b1;
                end else begin
                    examined = examined + CNT_W'(1);
                    if (match[i]) begin
                        hit     = 1'b1;
                        hit_idx = IDX_W'(i);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tlbmm_repl_adv.sv
module tlbmm_repl_adv #(
    parameter  int N      = 64,
    localparam int IDX_W  = $clog2(N),
    localparam int STEP_W = $clog2(N + 2)
) (
    input  logic [IDX_W-1:0]  cur,
    input  logic [IDX_W-1:0]  bound,
    input  logic [STEP_W-1:0] steps,
    output logic [IDX_W-1:0]  nxt
);
    localparam int MAX_STEPS = N + 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] c_acc;
    logic [IDX_W-1:0] c_inc;

    always_comb begin
        c_acc = cur;
        c_inc = '0;
        for (int i = 0; i < MAX_STEPS; i++) begin
            if (i < int'(steps)) begin
                c_inc = c_acc + IDX_W'(1);
                if (c_inc == bound || c_inc == LAST) c_acc = '0;
                else                                 c_acc = c_inc;
            end
        end
        nxt = c_acc;
    end
endmodule

// File: rtl/tlbmm_addr_array.sv
module tlbmm_addr_array
    import tlbmm_pkg::*;
#(
    parameter  int MT_ENTRIES = 64,
    parameter  int IT_ENTRIES = 4,
    localparam int IDX_W  = $clog2(MT_ENTRIES),
    localparam int IT_W   = $clog2(IT_ENTRIES),
    localparam int CNT_W  = $clog2(MT_ENTRIES + 1),
    localparam int STEP_W = $clog2(MT_ENTRIES + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            win_we,
    input  logic            win_re,
    input  logic [31:0]     win_addr,
    input  logic [31:0]     win_wdata,
    output logic [31:0]     win_rdata,
    output logic            win_err,
    input  logic            mt_lookup,
    input  logic            ctl_we,
    input  logic [31:0]     ctl_wdata,
    output logic [31:0]     ctl_word,
    input  logic            it_fill_we,
    input  logic [IT_W-1:0] it_fill_idx,
    input  logic [31:0]     it_fill_data,
    output logic            flush_req,
    output logic [31:0]     flush_addr,
    output logic            exc_pulse,
    output logic [11:0]     exc_code,
    output logic [31:0]     fault_addr
);
    localparam int CTR_LSB   = 10;
    localparam int BOUND_LSB = 18;
    localparam int IDX_LSB   = 8;
    localparam int MODE_BIT  = 7;

    typedef struct packed {
        tlb_ent_t [MT_ENTRIES-1:0] mt;
        tlb_ent_t [IT_ENTRIES-1:0] it;
        logic [IDX_W-1:0]          ctr;
        logic [IDX_W-1:0]          bound;
        logic [31:0]               rdata;
        logic                      err;
        logic                      flush;
        logic [31:0]               flush_addr;
        logic                      exc;
        logic [31:0]               fault;
    } state_t;

    state_t s_d, s_q;

    // decode of the window address
    acc_kind_e        kind;
    logic             assoc_mode;
    logic [IDX_W-1:0] sel_idx;
    tlb_ent_t         wr_ent;

    assign assoc_mode = win_addr[MODE_BIT];
    assign sel_idx    = win_addr[IDX_LSB +: IDX_W];
    assign wr_ent     = tlb_ent_t'(win_wdata);

    tlbmm_region_dec u_dec (
        .win_top (win_addr[31:27]),
        .region  (win_addr[26:24]),
        .kind    (kind)
    );

    // associative search of the main array
    logic             mt_hit;
    logic [IDX_W-1:0] mt_hit_idx;
    logic             mt_multi;
    logic [CNT_W-1:0] mt_examined;

    tlbmm_mt_search #(.N(MT_ENTRIES)) u_search (
        .ents     (s_q.mt),
        .key_vpn  (wr_ent.vpn),
        .key_asid (wr_ent.asid),
        .hit      (mt_hit),
        .hit_idx  (mt_hit_idx),
        .multi    (mt_multi),
        .examined (mt_examined)
    );

    // instruction TLB search: first page/identifier match, valid or not
    logic            it_hit;
    logic [IT_W-1:0] it_idx;
    logic            it_same_as_old;
    tlb_ent_t        old_ent;

    assign old_ent = s_q.mt[sel_idx];

    always_comb begin
        it_hit         = 1'b0;
        it_idx         = '0;
        it_same_as_old = 1'b0;
        for (int i = 0; i < IT_ENTRIES; i++) begin
            if (!it_hit && s_q.it[i].vpn == wr_ent.vpn
                        && s_q.it[i].asid == wr_ent.asid) begin
                it_hit = 1'b1;
                it_idx = IT_W'(i);
            end
            if (s_q.it[i] == old_ent) it_same_as_old = 1'b1;
        end
    end

    // replacement counter advance
    logic [STEP_W-1:0] ctr_steps;
    logic [IDX_W-1:0]  ctr_adv;
    logic              win_mt_write;

    assign win_mt_write = win_we && (kind == ACC_MAIN_TAG);

    always_comb begin
        ctr_steps = STEP_W'(mt_lookup);
        if (win_mt_write) begin
            if (assoc_mode) ctr_steps = ctr_steps + STEP_W'(mt_examined);
            else            ctr_steps = ctr_steps + STEP_W'(1);
        end
    end

    tlbmm_repl_adv #(.N(MT_ENTRIES)) u_adv (
        .cur   (s_q.ctr),
        .bound (s_q.bound),
        .steps (ctr_steps),
        .nxt   (ctr_adv)
    );

    // next-state logic
    logic drop_valid;

    always_comb begin
        s_d        = s_q;
        s_d.err    = 1'b0;
        s_d.flush  = 1'b0;
        s_d.exc    = 1'b0;
        drop_valid = 1'b0;

        if (win_we) begin
            unique case (kind)
                ACC_OUTSIDE_OR_BAD: s_d.err = 1'b1;
                ACC_MAIN_TAG: begin
                    if (!assoc_mode) begin
                        if (old_ent.v && !it_same_as_old) begin
                            s_d.flush      = 1'b1;
                            s_d.flush_addr = {old_ent.vpn, {PAGE_SHIFT{1'b0}}};
                        end
                        s_d.mt[sel_idx] = wr_ent;
                    end else begin
                        if (mt_hit) begin
                            if (s_q.mt[mt_hit_idx].v && !wr_ent.v) drop_valid = 1'b1;
                            s_d.mt[mt_hit_idx].v = wr_ent.v;
                            s_d.mt[mt_hit_idx].d = wr_ent.d;
                        end
                        if (mt_multi) begin
                            s_d.exc   = 1'b1;
                            s_d.fault = win_addr;
                        end
                        if (it_hit) begin
                            if (s_q.it[it_idx].v && !wr_ent.v) drop_valid = 1'b1;
                            if (mt_hit) s_d.it[it_idx]   = s_d.mt[mt_hit_idx];
                            else        s_d.it[it_idx].v = wr_ent.v;
                        end
                        if (drop_valid) begin
                            s_d.flush      = 1'b1;
                            s_d.flush_addr = {wr_ent.vpn, {PAGE_SHIFT{1'b0}}};
                        end
                    end
                end
                default: ;
            endcase
        end

        if (win_re) begin
            unique case (kind)
                ACC_OUTSIDE_OR_BAD: begin
                    s_d.err   = 1'b1;
                    s_d.rdata = '0;
                end
                ACC_MAIN_TAG: s_d.rdata = 32'(s_q.mt[sel_idx]);
                default:      s_d.rdata = '0;
            endcase
        end

        s_d.ctr = ctr_adv;
        if (ctl_we) begin
            s_d.ctr   = ctl_wdata[CTR_LSB +: IDX_W];
            s_d.bound = ctl_wdata[BOUND_LSB +: IDX_W];
        end

        if (it_fill_we) s_d.it[it_fill_idx] = tlb_ent_t'(it_fill_data);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MT_ENTRIES; i++) s_q.mt[i].v <= 1'b0;
            for (int i = 0; i < IT_ENTRIES; i++) s_q.it[i].v <= 1'b0;
            s_q.ctr        <= '0;
            s_q.bound      <= '0;
            s_q.rdata      <= '0;
            s_q.err        <= 1'b0;
            s_q.flush      <= 1'b0;
            s_q.flush_addr <= '0;
            s_q.exc        <= 1'b0;
            s_q.fault      <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    logic unused_ctl_bits;
    assign unused_ctl_bits = ^{ctl_wdata[31:BOUND_LSB+IDX_W],
                               ctl_wdata[BOUND_LSB-1:CTR_LSB+IDX_W],
                               ctl_wdata[CTR_LSB-1:0]};

    always_comb begin
        ctl_word = '0;
        ctl_word[CTR_LSB +: IDX_W]   = s_q.ctr;
        ctl_word[BOUND_LSB +: IDX_W] = s_q.bound;
    end

    assign win_rdata  = s_q.rdata;
    assign win_err    = s_q.err;
    assign flush_req  = s_q.flush;
    assign flush_addr = s_q.flush_addr;
    assign exc_pulse  = s_q.exc;
    assign exc_code   = s_q.exc ? EXC_MULTI_HIT : 12'h000;
    assign fault_addr = s_q.fault;

endmodule

// File: rtl/tlbmm_addr_array_chk.sv
module tlbmm_addr_array_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        win_we,
    input logic        win_re,
    input logic [31:0] win_addr,
    input logic        mt_lookup,
    input logic        ctl_we,
    input logic [31:0] ctl_word,
    input logic [31:0] win_rdata,
    input logic        win_err,
    input logic        flush_req,
    input logic        exc_pulse,
    input logic [31:0] fault_addr
);
    // R2 and R7: a flush only follows a window write
    p_flush_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> $past(win_we));

    // R5: exception follows an associative write and latches its address
    p_fault_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |-> ($past(win_we) && $past(win_addr[7]) && fault_addr == $past(win_addr)));

    // R10: an error pulse follows some window access
    p_err_after_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        win_err |-> $past(win_we || win_re));

    // R10: cache regions read as zero
    p_cache_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (win_re && win_addr[31:27] == 5'b11110 && !win_addr[25]) |=> (win_rdata == 32'h0));

    // R9: no access means the counter holds
    p_ctr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_we && !mt_lookup && !ctl_we) |=> $stable(ctl_word[15:10]));
endmodule

bind tlbmm_addr_array tlbmm_addr_array_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_we     (win_we),
    .win_re     (win_re),
    .win_addr   (win_addr),
    .mt_lookup  (mt_lookup),
    .ctl_we     (ctl_we),
    .ctl_word   (ctl_word),
    .win_rdata  (win_rdata),
    .win_err    (win_err),
    .flush_req  (flush_req),
    .exc_pulse  (exc_pulse),
    .fault_addr (fault_addr)
);

// File: tb/tlbmm_addr_array_bench.sv
module tlbmm_addr_array_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_we = 1'b0, win_re = 1'b0;
    logic [31:0] win_addr = '0, win_wdata = '0;
    logic [31:0] win_rdata;
    logic        win_err;
    logic        mt_lookup = 1'b0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_word;
    logic        it_fill_we = 1'b0;
    logic [1:0]  it_fill_idx = '0;
    logic [31:0] it_fill_data = '0;
    logic        flush_req;
    logic [31:0] flush_addr;
    logic        exc_pulse;
    logic [11:0] exc_code;
    logic [31:0] fault_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlbmm_addr_array u_tlbmm_addr_array (
        .clk(clk), .rst_n(rst_n),
        .win_we(win_we), .win_re(win_re), .win_addr(win_addr),
        .win_wdata(win_wdata), .win_rdata(win_rdata), .win_err(win_err),
        .mt_lookup(mt_lookup), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_word(ctl_word), .it_fill_we(it_fill_we), .it_fill_idx(it_fill_idx),
        .it_fill_data(it_fill_data), .flush_req(flush_req), .flush_addr(flush_addr),
        .exc_pulse(exc_pulse), .exc_code(exc_code), .fault_addr(fault_addr)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic        o_flush, o_exc, o_err;
    logic [31:0] o_faddr, o_fault, rd_val;
    logic [11:0] o_code;

    function automatic logic [31:0] ew(logic [21:0] vpn, logic d, logic v, logic [7:0] asid);
        return {vpn, d, v, asid};
    endfunction

    function automatic logic [31:0] mta(int idx, bit assoc);
        return 32'hF600_0000 | (32'(idx) << 8) | (assoc ? 32'h80 : 32'h0);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic capture();
        o_flush = flush_req; o_faddr = flush_addr; o_exc = exc_pulse;
        o_fault = fault_addr; o_code = exc_code; o_err = win_err;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); win_we = 1'b1; win_addr = a; win_wdata = d;
        @(negedge clk); win_we = 1'b0; capture();
    endtask

    task automatic rd(input logic [31:0] a);
        @(negedge clk); win_re = 1'b1; win_addr = a;
        @(negedge clk); win_re = 1'b0; rd_val = win_rdata; capture();
    endtask

    task automatic ctl(input int ctr, input int bound);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = (32'(ctr) << 10) | (32'(bound) << 18);
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic lookups(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); mt_lookup = 1'b1;
        end
        @(negedge clk); mt_lookup = 1'b0;
    endtask

    task automatic itfill(input int idx, input logic [31:0] d);
        @(negedge clk); it_fill_we = 1'b1; it_fill_idx = 2'(idx); it_fill_data = d;
        @(negedge clk); it_fill_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // index, write word, expected flush, expected flush address
    localparam logic [70:0] VEC [NVEC] = '{
        {6'd1,  22'h000ABC, 1'b0, 1'b1, 8'h11, 1'b0, 32'h0},
        {6'd2,  22'h001234, 1'b1, 1'b1, 8'h22, 1'b0, 32'h0},
        {6'd1,  22'h000DEF, 1'b0, 1'b1, 8'h11, 1'b1, 32'h002A_F000},
        {6'd63, 22'h3FFFFF, 1'b1, 1'b0, 8'hFF, 1'b0, 32'h0},
        {6'd63, 22'h000001, 1'b0, 1'b1, 8'h01, 1'b0, 32'h0},
        {6'd2,  22'h000055, 1'b0, 1'b0, 8'h22, 1'b1, 32'h0048_D000}
    };

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R11: reset state
        chk(ctl_word == 32'h0, "R11 ctl_word after reset", ctl_word, 32'h0);
        chk({flush_req, exc_pulse, win_err} == 3'b000, "R11 pulses after reset",
            {29'h0, flush_req, exc_pulse, win_err}, 32'h0);

        // R1/R2: table of indexed writes
        for (int k = 0; k < NVEC; k++) begin
            logic [31:0] wd;
            wd = VEC[k][64:33];
            wr(mta(int'(VEC[k][70:65]), 1'b0), wd);
            chk(o_flush == VEC[k][32], "R2 indexed flush", {31'h0, o_flush}, {31'h0, VEC[k][32]});
            if (VEC[k][32]) chk(o_faddr == VEC[k][31:0], "R2 flush address", o_faddr, VEC[k][31:0]);
            rd(mta(int'(VEC[k][70:65]), 1'b0));
            chk(rd_val == wd, "R1 readback", rd_val, wd);
        end
        chk(ctl_word == 32'h0000_1800, "R9 six indexed writes", ctl_word, 32'h0000_1800);

        // R11: valid flags cleared by reset
        do_reset();
        rd(mta(1, 1'b0));
        chk(rd_val[8] == 1'b0, "R11 valid cleared", {31'h0, rd_val[8]}, 32'h0);

        // R8: wrap at 63 and at boundary
        ctl(60, 0);
        lookups(2);
        chk(ctl_word == (32'd62 << 10), "R8 count to 62", ctl_word, 32'd62 << 10);
        lookups(1);
        chk(ctl_word == 32'h0, "R8 wrap at 63", ctl_word, 32'h0);
        ctl(0, 3);
        chk(ctl_word == 32'h000C_0000, "R8 bound field", ctl_word, 32'h000C_0000);
        lookups(2);
        chk(ctl_word == (32'h000C_0000 | (32'd2 << 10)), "R8 below bound", ctl_word,
            32'h000C_0000 | (32'd2 << 10));
        lookups(1);
        chk(ctl_word == 32'h000C_0000, "R8 wrap at bound", ctl_word, 32'h000C_0000);

        // R4/R5/R9: double match
        do_reset();
        wr(mta(10, 0), ew(22'h123, 0, 1, 8'h05));
        wr(mta(20, 0), ew(22'h123, 0, 1, 8'h05));
        wr(mta(30, 0), ew(22'h777, 0, 1, 8'h05));
        wr(mta(40, 0), ew(22'h123, 0, 0, 8'h05));
        chk(ctl_word == (32'd4 << 10), "R9 four indexed writes", ctl_word, 32'd4 << 10);
        ctl(0, 0);
        wr(mta(0, 1), ew(22'h123, 1, 1, 8'h05));
        chk(o_exc == 1'b1, "R5 exception pulse", {31'h0, o_exc}, 32'h1);
        chk(o_code == 12'h140, "R5 exception code", {20'h0, o_code}, 32'h140);
        chk(o_fault == 32'hF600_0080, "R5 fault address", o_fault, 32'hF600_0080);
        chk(o_flush == 1'b0, "R7 no flush when still valid", {31'h0, o_flush}, 32'h0);
        chk(ctl_word == (32'd1 << 10), "R9 search stops at second match", ctl_word, 32'd1 << 10);
        rd(mta(10, 0));
        chk(rd_val == ew(22'h123, 1, 1, 8'h05), "R4 first match updated", rd_val, ew(22'h123, 1, 1, 8'h05));
        rd(mta(20, 0));
        chk(rd_val == ew(22'h123, 0, 1, 8'h05), "R5 second match untouched", rd_val, ew(22'h123, 0, 1, 8'h05));
        rd(mta(40, 0));
        chk(rd_val == ew(22'h123, 0, 0, 8'h05), "R4 invalid entry untouched", rd_val, ew(22'h123, 0, 0, 8'h05));

        // R9: no match examines every valid entry
        ctl(0, 0);
        wr(mta(0, 1), ew(22'h999, 0, 1, 8'h07));
        chk(ctl_word == (32'd3 << 10), "R9 three valid entries examined", ctl_word, 32'd3 << 10);
        chk(o_exc == 1'b0, "R5 no exception without match", {31'h0, o_exc}, 32'h0);

        // R4/R7: identifier mismatch, then a clearing match
        wr(mta(0, 1), ew(22'h777, 0, 0, 8'h06));
        chk(o_flush == 1'b0, "R4 identifier mismatch ignored", {31'h0, o_flush}, 32'h0);
        rd(mta(30, 0));
        chk(rd_val[8] == 1'b1, "R4 mismatch leaves entry valid", {31'h0, rd_val[8]}, 32'h1);
        wr(mta(0, 1), ew(22'h777, 0, 0, 8'h05));
        chk(o_flush == 1'b1 && o_faddr == 32'h001D_DC00, "R7 flush on clear", o_faddr, 32'h001D_DC00);
        rd(mta(30, 0));
        chk(rd_val == ew(22'h777, 0, 0, 8'h05), "R4 entry cleared", rd_val, ew(22'h777, 0, 0, 8'h05));

        // R6/R3: copy into instruction TLB suppresses later flush
        do_reset();
        itfill(0, ew(22'h0AA, 0, 1, 8'h09));
        wr(mta(5, 0), ew(22'h0AA, 0, 1, 8'h09));
        wr(mta(0, 1), ew(22'h0AA, 1, 1, 8'h09));
        chk(o_flush == 1'b0, "R7 no flush on flag update", {31'h0, o_flush}, 32'h0);
        wr(mta(5, 0), ew(22'h0BB, 0, 1, 8'h09));
        chk(o_flush == 1'b0, "R3 R6 copied entry suppresses flush", {31'h0, o_flush}, 32'h0);

        // R6/R7: instruction-only match updates valid flag
        itfill(2, ew(22'h0CC, 0, 1, 8'h03));
        wr(mta(0, 1), ew(22'h0CC, 1, 0, 8'h03));
        chk(o_flush == 1'b1 && o_faddr == 32'h0003_3000, "R6 instruction entry cleared", o_faddr, 32'h0003_3000);
        wr(mta(0, 1), ew(22'h0CC, 1, 0, 8'h03));
        chk(o_flush == 1'b0, "R7 already invalid gives no flush", {31'h0, o_flush}, 32'h0);

        // R10: region handling
        ctl(5, 0);
        wr(32'hF100_0000, 32'hFFFF_FFFF);
        chk(o_err == 1'b0, "R10 cache write no error", {31'h0, o_err}, 32'h0);
        chk(ctl_word == (32'd5 << 10), "R10 cache write keeps counter", ctl_word, 32'd5 << 10);
        rd(32'hF400_0000);
        chk(rd_val == 32'h0 && o_err == 1'b0, "R10 cache read zero", rd_val, 32'h0);
        wr(32'hF300_0000, 32'h0);
        chk(o_err == 1'b1, "R10 region 3 error", {31'h0, o_err}, 32'h1);
        wr(32'hF700_0000, 32'h0);
        chk(o_err == 1'b1, "R10 region 7 error", {31'h0, o_err}, 32'h1);
        rd(32'hF200_0000);
        chk(o_err == 1'b1, "R10 region 2 read error", {31'h0, o_err}, 32'h1);
        wr(32'hE000_0000, 32'h0);
        chk(o_err == 1'b1, "R10 outside window error", {31'h0, o_err}, 32'h1);

        done = 1;
        report();
        $finish;
    end
endmodule